// File: doc/BRIEF.md
# Serial-Addressed Multichannel Converter Front End

This block is the digital face of a multichannel 10-bit converter that sits as a slave on a shared four-wire serial bus. A bus master lowers the active-low chip select and clocks ten bits. In the same exchange it sends the address of the next channel to convert and receives the result of the conversion it asked for in the previous exchange. The returned word therefore always lags the request by one frame, and the first frame after reset carries no real measurement.

The analog side is replaced by a behavioural value bus that holds one 10-bit word per channel. The block samples the addressed word at the end of a frame and runs a conversion window timed in conversion-clock cycles. It makes the word visible to the next frame only when that window has fully elapsed. A frame that starts inside the window is flagged with a one-cycle error pulse, and the unfinished conversion is thrown away. All serial inputs are sampled in the conversion-clock domain, so the serial clock must run well below the conversion clock (at least four conversion clocks per serial half period).

Top module: `adc_serial_slave`

## Requirements
- R1: A frame is 10 serial-clock periods. `din` is sampled on rising `sclk` edges. The first four bits received, MSB first, form the channel address, and the remaining six bits are ignored.
- R2: The returned word is shifted out MSB first (clock polarity 0, phase 0). The MSB is valid from the start of the frame, and each later bit appears after a falling `sclk` edge. `dout` stays stable while `sclk` is high.
- R3: `sdoDrive` rises no later than 2 `convClk` cycles after `csN` falls and drops no later than 2 cycles after `csN` rises. `dout` is high impedance whenever `sdoDrive` is low.
- R4: The word returned in a frame is the conversion requested by the last preceding frame that completed all ten bits. Before any conversion has finished, the returned word is all zeros.
- R5: The channel value is captured when the tenth falling `sclk` edge of the frame is seen. A change on `chanValues` after that point does not alter the result.
- R6: Addresses 11 to 15 select no channel, and their conversion yields all zeros.
- R7: The conversion completes when `csN` next falls more than 44 `convClk` cycles after the tenth falling `sclk` edge. The gap is counted as whole clock periods between the two pin changes, and a gap of exactly 45 already completes the conversion.
- R8: If `csN` falls 44 or fewer cycles after the tenth falling edge, `earlyErr` pulses high for exactly one cycle. The frame returns the previously held word, and the abandoned conversion is never delivered.
- R9: A frame that ends with fewer than ten serial-clock periods starts no conversion. The next frame returns the same held word and raises no error, whatever gap precedes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| convClk | input | 1 | Conversion clock; every register runs on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select from the bus master |
| sclk | input | 1 | Serial clock from the master, idles low |
| din | input | 1 | Serial address data from the master |
| chanValues | input | 110 | Behavioural channel values, channel n at bits [10n+9:10n] |
| dout | output | 1 | Serial result data, high impedance outside a frame |
| sdoDrive | output | 1 | High while `dout` is driven |
| earlyErr | output | 1 | One-cycle pulse on a frame that starts inside the conversion window |

## Verification
The falling edge of chip select can be seen in the same cycle as the last count of the conversion window. In that cycle the block must choose between committing the sampled word and reporting an early frame. The bench provokes this by opening frames at gaps of 44 and 45 clock periods after the tenth falling edge. It judges both the error count during the frame and the word returned in the frame after. A one-cycle miss in either direction is exposed, because the two gaps give opposite results for both observables.

// File: rtl/adc_serial_slave_pkg.sv
package adc_serial_slave_pkg;

  // Strobes from the frame control to the datapath, one per register action.
  typedef struct packed {
    logic loadTx;       // frame opened: copy held result into output shifter
    logic shiftTx;      // falling serial edge inside frame: next result bit
    logic shiftRx;      // rising serial edge, address still incomplete
    logic latchSample;  // tenth falling edge: capture addressed channel value
    logic commit;       // conversion window over: publish sampled value
  } strobe_t;

endpackage

// File: rtl/adc_serial_slave_in.sv
module adc_serial_slave_in (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic din,
  output logic csActive,
  output logic csFallEv,
  output logic sclkRiseEv,
  output logic sclkFallEv,
  output logic dinS
);

  logic csS, csP, sclkS, sclkP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS   <= 1'b1;
      csP   <= 1'b1;
      sclkS <= 1'b0;
      sclkP <= 1'b0;
      dinS  <= 1'b0;
    end else begin
      csS   <= csN;
      csP   <= csS;
      sclkS <= sclk;
      sclkP <= sclkS;
      dinS  <= din;
    end
  end

  assign csActive   = !csS;
  assign csFallEv   = !csS && csP;
  assign sclkRiseEv = sclkS && !sclkP;
  assign sclkFallEv = !sclkS && sclkP;

endmodule

// File: rtl/adc_serial_slave_ctrl.sv
module adc_serial_slave_ctrl
  import adc_serial_slave_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int CONV_CYCLES = 44
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csActive,
  input  logic    csFallEv,
  input  logic    sclkRiseEv,
  input  logic    sclkFallEv,
  output strobe_t stb,
  output logic    sdoDrive,
  output logic    earlyErr
);

  localparam int BIT_W = $clog2(RES_W + 1);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RES_W);
  localparam logic [BIT_W-1:0] ADDR_END = BIT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [BIT_W-1:0] riseCnt, fallCnt;
  logic [CNT_W-1:0] winCnt;
  logic             busy;
  logic             inFrame;

  assign inFrame = csActive && !csFallEv;

  always_comb begin
    stb             = '0;
    stb.loadTx      = csFallEv;
    stb.shiftRx     = inFrame && sclkRiseEv && (riseCnt < ADDR_END);
    stb.shiftTx     = inFrame && sclkFallEv && (fallCnt < LAST_BIT);
    stb.latchSample = inFrame && sclkFallEv && (fallCnt == LAST_BIT - 1'b1)
                      && (riseCnt == LAST_BIT);
    stb.commit      = busy && (winCnt == '0) && !csFallEv;
  end

  // Serial edge counters, cleared when a frame opens.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
      fallCnt <= '0;
    end else if (csFallEv) begin
      riseCnt <= '0;
      fallCnt <= '0;
    end else if (csActive) begin
      if (sclkRiseEv && riseCnt < LAST_BIT) riseCnt <= riseCnt + 1'b1;
      if (sclkFallEv && fallCnt < LAST_BIT) fallCnt <= fallCnt + 1'b1;
    end
  end

  // Conversion window: busy for CONV_CYCLES cycles after the sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      winCnt <= '0;
    end else if (csFallEv) begin
      busy   <= 1'b0;
      winCnt <= '0;
    end else if (stb.latchSample) begin
      busy   <= 1'b1;
      winCnt <= WIN_LOAD;
    end else if (busy) begin
      if (winCnt == '0) busy <= 1'b0;
      else winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyErr <= 1'b0;
      sdoDrive <= 1'b0;
    end else begin
      earlyErr <= csFallEv && busy;
      sdoDrive <= csActive;
    end
  end

endmodule

// File: rtl/adc_serial_slave_dp.sv
module adc_serial_slave_dp
  import adc_serial_slave_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic                    dinS,
  input  logic [NUM_CH*RES_W-1:0] chanFlat,
  output logic                    txBit
);

  localparam int SLOTS = 2 ** ADDR_W;

  logic [RES_W-1:0]  chanArr [SLOTS];
  logic [ADDR_W-1:0] rxAddr;
  logic [RES_W-1:0]  sampleReg, resultReg, txShift;

  // Populated slots map to channels; unpopulated addresses read as zero.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_CH) begin : g_live
      assign chanArr[g] = chanFlat[g*RES_W +: RES_W];
    end else begin : g_empty
      assign chanArr[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAddr    <= '0;
      sampleReg <= '0;
      resultReg <= '0;
      txShift   <= '0;
    end else begin
      if (stb.shiftRx)     rxAddr    <= {rxAddr[ADDR_W-2:0], dinS};
      if (stb.latchSample) sampleReg <= chanArr[rxAddr];
      if (stb.commit)      resultReg <= sampleReg;
      if (stb.loadTx)       txShift  <= resultReg;
      else if (stb.shiftTx) txShift  <= {txShift[RES_W-2:0], 1'b0};
    end
  end

  assign txBit = txShift[RES_W-1];

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_serial_slave_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int NUM_CH      = 11,
  parameter int CONV_CYCLES = 44
) (
  input  logic                    convClk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    sclk,
  input  logic                    din,
  input  logic [NUM_CH*RES_W-1:0] chanValues,
  output logic                    dout,
  output logic                    sdoDrive,
  output logic                    earlyErr
);

  logic    csActive, csFallEv, sclkRiseEv, sclkFallEv, dinS;
  logic    txBit;
  strobe_t stb;

  adc_serial_slave_in u_in (
    .clk        (convClk),
    .rstN       (rstN),
    .csN        (csN),
    .sclk       (sclk),
    .din        (din),
    .csActive   (csActive),
    .csFallEv   (csFallEv),
    .sclkRiseEv (sclkRiseEv),
    .sclkFallEv (sclkFallEv),
    .dinS       (dinS)
  );

  adc_serial_slave_ctrl #(
    .RES_W       (RES_W),
    .ADDR_W      (ADDR_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_ctrl (
    .clk        (convClk),
    .rstN       (rstN),
    .csActive   (csActive),
    .csFallEv   (csFallEv),
    .sclkRiseEv (sclkRiseEv),
    .sclkFallEv (sclkFallEv),
    .stb        (stb),
    .sdoDrive   (sdoDrive),
    .earlyErr   (earlyErr)
  );

  adc_serial_slave_dp #(
    .RES_W  (RES_W),
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk      (convClk),
    .rstN     (rstN),
    .stb      (stb),
    .dinS     (dinS),
    .chanFlat (chanValues),
    .txBit    (txBit)
  );

  assign dout = sdoDrive ? txBit : 1'bz;

endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic sdoDrive,
  input logic txBit,
  input logic earlyErr
);

  logic [1:0] age;
  logic       ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end
  assign ready = (age == 2'd3);

  // R3: select held low for three samples means the output is driven
  assert_drive_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(csN, 2) && !$past(csN) && !csN) |-> sdoDrive);

  // R3: select held high for three samples means the output is released
  assert_drive_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(csN, 2) && $past(csN) && csN) |-> !sdoDrive);

  // R8: the early-frame flag lasts a single cycle
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    earlyErr |=> !earlyErr);

  // R8: the early-frame flag only appears inside a driven frame
  assert_err_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    earlyErr |-> sdoDrive);

  // R2: the result bit holds while the serial clock has been high
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && sdoDrive && $past(sdoDrive) && $past(sclk, 2)) |-> $stable(txBit));

endmodule

bind adc_serial_slave adc_serial_slave_chk u_chk (
  .clk      (convClk),
  .rstN     (rstN),
  .csN      (csN),
  .sclk     (sclk),
  .sdoDrive (sdoDrive),
  .txBit    (txBit),
  .earlyErr (earlyErr)
);

// File: tb/adc_serial_slave_tb.sv
module adc_serial_slave_tb;
  localparam int RES = 10;
  localparam int NCH = 11;
  localparam int WIN = 44;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [NCH*RES-1:0] chanValues;
  logic [RES-1:0] chanV [NCH];
  wire  dout;
  logic sdoDrive, earlyErr;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) chanValues[i*RES +: RES] = chanV[i];

  adc_serial_slave u_dut (
    .convClk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .chanValues(chanValues), .dout(dout), .sdoDrive(sdoDrive), .earlyErr(earlyErr)
  );

  int tests = 0, fails = 0, cyc = 0, errCount = 0, lastFallCyc = 0;
  bit done = 1'b0;
  logic [2:0] csHist = 3'b000;
  logic [RES-1:0] held, pend;
  bit pendValid;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  always @(posedge clk) cyc++;

  // Per-clock checks of the drive window (R3) and error pulse tally.
  always @(negedge clk) begin
    if (rstN) begin
      logic [2:0] h;
      h = {csHist[1:0], csN};
      csHist <= h;
      if (earlyErr) errCount++;
      if (h == 3'b111) chk(!sdoDrive, "R3", "output released", sdoDrive, 0);
      if (h == 3'b000) chk(sdoDrive && (dout !== 1'bz), "R3", "output driven", sdoDrive, 1);
    end
  end

  task automatic doFrame(input logic [3:0] addr, input int nbits, input int gap,
                         input string tag);
    logic [RES-1:0] word, got, expWord;
    int gapNow, e0;
    bit expErr;
    if (gap > 0) while (cyc - lastFallCyc < gap) tick(1);
    gapNow = cyc - lastFallCyc;
    expErr = pendValid && (gapNow <= WIN);
    if (pendValid && !expErr) held = pend;
    pendValid = 1'b0;
    expWord = held;
    e0 = errCount;
    word = {addr, 6'b0};
    got = '0;
    csN = 1'b0;
    tick(3);
    for (int i = 0; i < nbits; i++) begin
      din = word[RES-1-i];
      tick(3);
      @(negedge clk);
      got[RES-1-i] = dout;
      tick(1);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      lastFallCyc = cyc;
      tick(3);
    end
    csN = 1'b1;
    tick(2);
    chk((errCount - e0) == int'(expErr), expErr ? "R8" : "R7", "early pulses",
        errCount - e0, int'(expErr));
    for (int i = 0; i < nbits; i++)
      chk(got[RES-1-i] === expWord[RES-1-i], tag, "result bit", got[RES-1-i],
          expWord[RES-1-i]);
    if (nbits == RES) begin
      pend = (addr < NCH) ? chanV[addr] : '0;
      pendValid = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chanV[i] = RES'(10'h2A5 ^ (i * 37));
    held = '0; pend = '0; pendValid = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(4);
    @(negedge clk);
    chk(!sdoDrive, "R3", "reset drive", sdoDrive, 0);
    chk(!earlyErr, "R8", "reset error", earlyErr, 0);
    tick(1);
    doFrame(4'd3, RES, 0, "R4");   // first frame after reset: zeros
    doFrame(4'd4, RES, 60, "R1");  // returns channel 3
    doFrame(4'd6, RES, 60, "R4");  // returns channel 4
    doFrame(4'd12, RES, 60, "R4"); // returns channel 6
    doFrame(4'd10, RES, 60, "R6"); // returns zero from address 12
    doFrame(4'd0, RES, 20, "R8");  // early: held word again
    doFrame(4'd5, RES, 44, "R8");  // boundary early
    doFrame(4'd7, RES, 45, "R7");  // boundary legal: channel 5
    doFrame(4'd2, 5, 46, "R2");    // short frame, channel 7 head
    doFrame(4'd9, RES, 10, "R9");  // no conversion pending: channel 7, no error
    for (int i = 0; i < NCH; i++) chanV[i] = RES'(10'h15A + i * 71);
    doFrame(4'd8, RES, 50, "R5");  // old channel 9 value captured earlier
    doFrame(4'd1, RES, 60, "R5");  // new channel 8 value
    doFrame(4'd15, RES, 60, "R1"); // returns channel 1
    doFrame(4'd3, RES, 60, "R6");  // zero from address 15
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule